// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This block carries out one single-bit operation on a byte in memory: set the bit, invert it, clear it, or only test it. On a start pulse it latches the operands. It forms the byte address from a base value plus a sign-extended 16-bit displacement. It then issues a one-byte read and waits for the returned data.

The zero flag comes from the selected bit as it was before any change. For set, invert and clear, the modified byte is written back to the same address. A test operation never writes. Each operation ends with a one-cycle completion pulse.

The unit is meant to sit beside an instruction sequencer. The sequencer merges the zero flag into its own status word, and an arbiter connects the read and write requests to the memory.

Top module: `mem_bit_unit`

## Requirements
- R1: While reset is asserted and after it is released, rd_req_o, wr_req_o, done_o and zero_o are all 0.
- R2: A start_i sampled high in idle raises rd_req_o for exactly one cycle, in the next cycle. rd_addr_o equals base_i plus disp_i sign-extended to the address width, modulo 2^AW.
- R3: bit_idx_i selects bit n of the byte, with bit 0 as the least significant bit.
- R4: After the read request, the unit waits any number of cycles for rd_valid_i. It issues no request while it waits, and it captures rd_data_i in the first cycle in which rd_valid_i is high.
- R5: In the cycle after capture, zero_o is 1 if the selected bit of the captured byte was 0, and 0 otherwise. zero_o changes at no other time.
- R6: The op_i encodings are 0 = set, 1 = invert, 2 = clear, 3 = test. For set, invert and clear, wr_req_o is high for one cycle, in the cycle after capture. That cycle carries wr_addr_o equal to the read address and wr_data_o equal to the captured byte with the selected bit forced to 1, toggled, or forced to 0.
- R7: A test operation (op 3) never raises wr_req_o.
- R8: done_o is a one-cycle pulse. It comes in the cycle after the write cycle, or in the cycle after capture for a test operation. The unit is idle again in the following cycle.
- R9: start_i is ignored while an operation is in progress. The operands in effect are those sampled with the accepted start.
- R10: rd_req_o and wr_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only in idle) |
| op_i | input | 2 | Operation: 0 set, 1 invert, 2 clear, 3 test |
| base_i | input | AW | Base address value |
| disp_i | input | DISPW | Signed displacement |
| bit_idx_i | input | 3 | Bit number within the byte |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | AW | Byte read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| wr_req_o | output | 1 | Byte write request |
| wr_addr_o | output | AW | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| zero_o | output | 1 | Zero flag, set when the selected bit was 0 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties watch every cycle for several rules:
- the read request, the write request and the done pulse each last one cycle;
- the two requests never overlap;
- a test operation never writes;
- the zero flag holds except in the cycle after data capture.

Other behaviour is visible only in the bench's sweeps, which cover every operation, every bit index and several data patterns and read latencies:
- the correct address arithmetic with negative displacements;
- the exact modified byte;
- the flag polarity;
- operands that stay fixed when a start arrives in mid-operation.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_INV = 2'd1,
    OP_CLR = 2'd2,
    OP_TST = 2'd3
  } mbm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } mbm_state_e;
endpackage

// File: rtl/mbm_addr_gen.sv
module mbm_addr_gen #(
  parameter int AW    = 32,
  parameter int DISPW = 16
) (
  input  logic [AW-1:0]    base_i,
  input  logic [DISPW-1:0] disp_i,
  output logic [AW-1:0]    addr_o
);
  localparam int EXTW = AW - DISPW;

  logic [AW-1:0] disp_ext;

  generate
    if (EXTW > 0) begin : g_ext
      assign disp_ext = {{EXTW{disp_i[DISPW-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[AW-1:0];
    end
  endgenerate

  assign addr_o = base_i + disp_ext;
endmodule

// File: rtl/mbm_bit_alu.sv
module mbm_bit_alu
  import mbm_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  mbm_op_e       op_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          zero_o
);
  logic [DW-1:0] mask;

  assign mask   = DW'(1) << idx_i;
  assign zero_o = ~|(data_i & mask);

  always_comb begin
    unique case (op_i)
      OP_SET:  data_o = data_i | mask;
      OP_INV:  data_o = data_i ^ mask;
      OP_CLR:  data_o = data_i & ~mask;
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_valid_i,
  input  logic is_test_i,
  output logic launch_o,
  output logic capture_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic done_o
);
  mbm_state_e state_q, state_d;

  assign launch_o  = (state_q == ST_IDLE) && start_i;
  assign capture_o = (state_q == ST_WAIT) && rd_valid_i;
  assign rd_req_o  = (state_q == ST_READ);
  assign wr_req_o  = (state_q == ST_WRITE);
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  if (rd_valid_i) state_d = is_test_i ? ST_DONE : ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R2
  rd_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !rd_req_o && !wr_req_o);

  // R10
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
endmodule

// File: rtl/mem_bit_unit.sv
module mem_bit_unit
  import mbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DISPW = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [AW-1:0]    base_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [IW-1:0]    bit_idx_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             wr_req_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             zero_o,
  output logic             done_o
);
  logic          launch, capture;
  logic [AW-1:0] addr_d, addr_q;
  mbm_op_e       op_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] new_byte, wdata_q;
  logic          bit_zero, zero_q;

  mbm_addr_gen #(.AW(AW), .DISPW(DISPW)) u_addr (
    .base_i (base_i),
    .disp_i (disp_i),
    .addr_o (addr_d)
  );

  mbm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_valid_i (rd_valid_i),
    .is_test_i  (op_q == OP_TST),
    .launch_o   (launch),
    .capture_o  (capture),
    .rd_req_o   (rd_req_o),
    .wr_req_o   (wr_req_o),
    .done_o     (done_o)
  );

  mbm_bit_alu #(.DW(DW)) u_alu (
    .op_i   (op_q),
    .idx_i  (idx_q),
    .data_i (rd_data_i),
    .data_o (new_byte),
    .zero_o (bit_zero)
  );

  // operands frozen at accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      op_q   <= OP_SET;
      idx_q  <= '0;
    end else if (launch) begin
      addr_q <= addr_d;
      op_q   <= mbm_op_e'(op_i);
      idx_q  <= bit_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      zero_q  <= 1'b0;
    end else if (capture) begin
      wdata_q <= new_byte;
      zero_q  <= bit_zero;
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = wdata_q;
  assign zero_o    = zero_q;

  // R5
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(zero_o));

  // R7
  no_test_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> op_q != OP_TST);

  // R6
  wr_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o && done_o);
endmodule

// File: tb/tb_mem_bit_unit.sv
`timescale 1ns/1ps
module tb_mem_bit_unit;
  localparam int AW = 32;
  localparam int DISPW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] base = '0;
  logic [DISPW-1:0] disp = '0;
  logic [2:0] bidx = '0;
  logic rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic rd_req, wr_req, zero, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mem_bit_unit #(.AW(AW), .DISPW(DISPW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .base_i(base), .disp_i(disp), .bit_idx_i(bidx),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .zero_o(zero), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] b,
                        input logic [DISPW-1:0] d, input logic [2:0] n,
                        input logic [DW-1:0] byt, input int lat);
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_data;
    logic exp_zero;
    exp_addr = b + {{(AW-DISPW){d[DISPW-1]}}, d};
    exp_zero = ((byt >> n) & 8'd1) == 8'd0;
    case (o)
      2'd0: exp_data = byt | (8'd1 << n);
      2'd1: exp_data = byt ^ (8'd1 << n);
      2'd2: exp_data = byt & ~(8'd1 << n);
      default: exp_data = byt;
    endcase
    @(negedge clk);
    start = 1'b1; op = o; base = b; disp = d; bidx = n;
    @(negedge clk);
    start = 1'b0;
    chk("R2 rd_req", rd_req, 1);
    chk("R2 rd_addr", rd_addr, exp_addr);
    chk("R10 wr_req during read", wr_req, 0);
    @(negedge clk);
    for (int i = 0; i < lat; i++) begin
      chk("R4 no rd_req while waiting", rd_req, 0);
      chk("R4 no wr_req while waiting", wr_req, 0);
      if (i == 0) begin
        start = 1'b1; op = ~o; base = ~b; disp = ~d; bidx = ~n;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rd_valid = 1'b1; rd_data = byt;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = ~byt;
    chk("R5 zero flag", zero, exp_zero);
    if (o != 2'd3) begin
      chk("R6 wr_req", wr_req, 1);
      chk("R6 wr_addr", wr_addr, exp_addr);
      chk("R3 R6 R9 wr_data", wr_data, exp_data);
      chk("R8 no early done", done, 0);
      @(negedge clk);
    end else begin
      chk("R7 test no write", wr_req, 0);
    end
    chk("R8 done", done, 1);
    chk("R10 wr_req at done", wr_req, 0);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R9 no stray read", rd_req, 0);
    chk("R5 zero held", zero, exp_zero);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    #1;
    chk("R1 rd_req in reset", rd_req, 0);
    chk("R1 done in reset", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 done", done, 0);
    chk("R1 zero", zero, 0);
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 8; n++)
        for (int p = 0; p < 4; p++)
          run_op(2'(o), 32'h1000_0000 + 32'(n * 64), 16'(16'h8000 + p * 16'h1235 + n),
                 3'(n), pats[p], (o + n + p) % 4);
    run_op(2'd0, 32'h0000_0004, 16'hFFF8, 3'd7, 8'h00, 1);
    run_op(2'd3, 32'hFFFF_FFFF, 16'h0001, 3'd0, 8'h01, 5);
    run_op(2'd2, 32'h0000_0000, 16'h7FFF, 3'd3, 8'h08, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule